// File: doc/BRIEF.md
# NAND Hamming ECC accumulator

This block sits beside the byte-wide data path of a NAND flash controller and builds a single-error-correcting Hamming code over the bytes that cross it. It does not produce or consume those bytes. It observes the valid/ready handshake of the path and counts one beat on each cycle where both are high. Every 256 accepted bytes form a chunk. Each chunk gets three code bytes: two hold 16 line-parity bits and one holds 6 column-parity bits. All stored parities are presented inverted, and the two unused bits of the column byte read as 1. With the default of two chunks, a 512-byte page yields six code bytes.

A 2-bit mode input, driven from a control register elsewhere, selects the operation:

| Mode | Effect |
|------|--------|
| 00 | Freeze the code state. |
| 01 | Accumulate accepted beats. |
| 10 | Stream out the code bytes. |
| 11 | Clear all state. |

Software starts a calculation by passing through clear, then freeze, then accumulate. To collect the result, it selects freeze, then read-out, and pops the bytes from the code stream. Correction of data against the code is left to software.

The code stream is valid/ready. While the mode is 10 and bytes remain, `code_valid` is high and `code_data` holds the current byte. A byte is consumed on a cycle with `code_valid` and `code_ready` both high. While `code_ready` is low, the same byte is held indefinitely. Leaving mode 10 rewinds the stream to its first byte.

Top module: `ecc_hamming_acc`

## Requirements
- R1: After reset, `code_valid` is low. Every code byte reads 8'hFF, because all parities are cleared.
- R2: In mode 00 and in mode 10, beats on the data path are ignored, and the code state and byte position hold.
- R3: In mode 01, a beat is counted only on a cycle with `dat_valid` and `dat_ready` both high. Each counted beat updates the parities of the current chunk at the current byte position.
- R4: Mode 11 clears every parity and the byte position. A beat in the same cycle as mode 11 is discarded.
- R5: For byte address a (0..255) in a chunk, let P be the XOR of all 8 bits of the byte. P toggles line parity bit 2k when bit k of a is 0, and bit 2k+1 when bit k of a is 1, for k = 0..7. Code byte 0 is ~lp[7:0] and code byte 1 is ~lp[15:8].
- R6: Column parities are defined as follows:
  - c0 is the XOR of data bits 0,2,4,6.
  - c1 is the XOR of bits 1,3,5,7.
  - c2 is the XOR of bits 0,1,4,5.
  - c3 is the XOR of bits 2,3,6,7.
  - c4 is the XOR of bits 0..3.
  - c5 is the XOR of bits 4..7.
  
  Each is accumulated over the chunk. Code byte 2 is {~c5,~c4,~c3,~c2,~c1,~c0,1,1}.
- R7: After 256 counted beats, accumulation moves to the next chunk. Once NCHUNKS*256 beats have been counted, further beats are ignored until a clear.
- R8: In mode 10, bytes stream in the order code byte 1, byte 0, byte 2 of chunk 0, then the same order for each following chunk. The stream advances only on `code_valid && code_ready`, and `code_data` holds while `code_ready` is low.
- R9: After the last code byte is consumed, `code_valid` stays low for as long as mode 10 is held.
- R10: Any cycle with a mode other than 10 rewinds the stream, so the next read-out starts again at byte 1 of chunk 0.
- R11: Reading out does not disturb the code. A second read-out returns the same bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 freeze, 01 accumulate, 10 read-out, 11 clear |
| dat_valid | input | 1 | Valid of the observed data path |
| dat_ready | input | 1 | Ready of the observed data path |
| dat_byte | input | 8 | Byte on the observed data path |
| code_valid | output | 1 | A code byte is available |
| code_ready | input | 1 | Consumer takes the code byte |
| code_data | output | 8 | Current code byte |

## Verification
Two functions can collide in one cycle.

The first is a clear arriving together with a handshaken data beat. The bench raises mode 11 and a full handshake on the same edge. It then accumulates a known chunk and judges that the stored code matches that chunk alone, with no shift in addresses.

The second is a handshake on the 256th beat, which both finishes one chunk and points the next beat at the following chunk. A full 512-byte page with stalled, unaccepted beats mixed in exposes an off-by-one there. The bench also drives accepted beats past the end of the page and checks that the six-byte code is unchanged.

// File: rtl/ecc_hamming_pkg.sv
package ecc_hamming_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_ACC  = 2'b01,
    MODE_READ = 2'b10,
    MODE_CLR  = 2'b11
  } ecc_mode_e;

  localparam int unsigned CHUNK_AW   = 8;
  localparam int unsigned LINE_BITS  = 2 * CHUNK_AW;
  localparam int unsigned COL_BITS   = 6;
  localparam int unsigned CODE_BYTES = 3;

  function automatic logic [COL_BITS-1:0] col_parity(input logic [7:0] d);
    logic [COL_BITS-1:0] c;
    c[0] = d[0] ^ d[2] ^ d[4] ^ d[6];
    c[1] = d[1] ^ d[3] ^ d[5] ^ d[7];
    c[2] = d[0] ^ d[1] ^ d[4] ^ d[5];
    c[3] = d[2] ^ d[3] ^ d[6] ^ d[7];
    c[4] = ^d[3:0];
    c[5] = ^d[7:4];
    return c;
  endfunction

endpackage

// File: rtl/ecc_position_tracker.sv
module ecc_position_tracker
  import ecc_hamming_pkg::*;
#(
  parameter int unsigned NCHUNKS = 2,
  localparam int unsigned CW = $clog2(NCHUNKS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                beat,
  output logic [CHUNK_AW-1:0] byte_idx,
  output logic [CW-1:0]       chunk_idx,
  output logic                full
);

  localparam logic [CW-1:0]       LAST_CHUNK = CW'(NCHUNKS);
  localparam logic [CHUNK_AW-1:0] LAST_BYTE  = '1;

  assign full = (chunk_idx == LAST_CHUNK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_idx  <= '0;
      chunk_idx <= '0;
    end else if (clr) begin
      byte_idx  <= '0;
      chunk_idx <= '0;
    end else if (beat && !full) begin
      byte_idx <= byte_idx + 1'b1;
      if (byte_idx == LAST_BYTE) chunk_idx <= chunk_idx + 1'b1;
    end
  end

endmodule

// File: rtl/ecc_chunk_parity.sv
module ecc_chunk_parity
  import ecc_hamming_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                upd,
  input  logic [CHUNK_AW-1:0] addr,
  input  logic [7:0]          data,
  output logic [7:0]          code_lo,
  output logic [7:0]          code_hi,
  output logic [7:0]          code_col
);

  logic [LINE_BITS-1:0] lp_q;
  logic [LINE_BITS-1:0] lp_flip;
  logic [COL_BITS-1:0]  cp_q;
  logic                 bpar;

  assign bpar = ^data;

  for (genvar k = 0; k < CHUNK_AW; k++) begin : g_line
    assign lp_flip[2*k]   = bpar & ~addr[k];
    assign lp_flip[2*k+1] = bpar &  addr[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (clr) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (upd) begin
      lp_q <= lp_q ^ lp_flip;
      cp_q <= cp_q ^ col_parity(data);
    end
  end

  assign code_lo  = ~lp_q[7:0];
  assign code_hi  = ~lp_q[15:8];
  assign code_col = {~cp_q, 2'b11};

endmodule

// File: rtl/ecc_readout_seq.sv
module ecc_readout_seq #(
  parameter int unsigned NCHUNKS = 2,
  localparam int unsigned CW = $clog2(NCHUNKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          pop,
  output logic [1:0]    slot,
  output logic [CW-1:0] chunk_sel,
  output logic          more
);

  localparam logic [CW-1:0] END_CHUNK = CW'(NCHUNKS);

  assign more = (chunk_sel != END_CHUNK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot      <= '0;
      chunk_sel <= '0;
    end else if (!active) begin
      slot      <= '0;
      chunk_sel <= '0;
    end else if (pop && more) begin
      if (slot == 2'd2) begin
        slot      <= '0;
        chunk_sel <= chunk_sel + 1'b1;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ecc_hamming_acc.sv
module ecc_hamming_acc
  import ecc_hamming_pkg::*;
#(
  parameter int unsigned NCHUNKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       dat_valid,
  input  logic       dat_ready,
  input  logic [7:0] dat_byte,
  output logic       code_valid,
  input  logic       code_ready,
  output logic [7:0] code_data
);

  localparam int unsigned CW = $clog2(NCHUNKS + 1);

  ecc_mode_e           mode_q;
  logic                clr;
  logic                beat;
  logic [CHUNK_AW-1:0] pos_byte;
  logic [CW-1:0]       pos_chunk;
  logic                pos_full;
  logic [1:0]          rd_slot;
  logic [CW-1:0]       rd_chunk;
  logic                rd_more;
  logic                rd_active;
  logic [7:0]          c_lo  [NCHUNKS];
  logic [7:0]          c_hi  [NCHUNKS];
  logic [7:0]          c_col [NCHUNKS];

  assign mode_q    = ecc_mode_e'(mode);
  assign clr       = (mode_q == MODE_CLR);
  assign beat      = (mode_q == MODE_ACC) && dat_valid && dat_ready;
  assign rd_active = (mode_q == MODE_READ);

  ecc_position_tracker #(.NCHUNKS(NCHUNKS)) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .beat     (beat),
    .byte_idx (pos_byte),
    .chunk_idx(pos_chunk),
    .full     (pos_full)
  );

  for (genvar g = 0; g < NCHUNKS; g++) begin : g_chunk
    logic upd_g;
    assign upd_g = beat && !pos_full && (pos_chunk == CW'(g));
    ecc_chunk_parity u_par (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .upd     (upd_g),
      .addr    (pos_byte),
      .data    (dat_byte),
      .code_lo (c_lo[g]),
      .code_hi (c_hi[g]),
      .code_col(c_col[g])
    );
  end

  ecc_readout_seq #(.NCHUNKS(NCHUNKS)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (rd_active),
    .pop      (code_valid && code_ready),
    .slot     (rd_slot),
    .chunk_sel(rd_chunk),
    .more     (rd_more)
  );

  assign code_valid = rd_active && rd_more;

  always_comb begin
    code_data = 8'h00;
    for (int c = 0; c < NCHUNKS; c++) begin
      if (rd_chunk == CW'(c)) begin
        case (rd_slot)
          2'd0:    code_data = c_hi[c];
          2'd1:    code_data = c_lo[c];
          default: code_data = c_col[c];
        endcase
      end
    end
  end

endmodule

// File: rtl/ecc_hamming_acc_chk.sv
module ecc_hamming_acc_chk
  import ecc_hamming_pkg::*;
#(
  parameter int unsigned NCHUNKS = 2,
  localparam int unsigned CW = $clog2(NCHUNKS + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          mode,
  input logic                dat_valid,
  input logic                dat_ready,
  input logic                code_valid,
  input logic                code_ready,
  input logic [7:0]          code_data,
  input logic [CHUNK_AW-1:0] byte_idx,
  input logic [CW-1:0]       chunk_idx,
  input logic [1:0]          rd_slot,
  input logic [CW-1:0]       rd_chunk
);

  localparam logic [CW-1:0] LAST = CW'(NCHUNKS);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CLR) |=> (byte_idx == '0 && chunk_idx == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF || mode == MODE_READ) |=> ($stable(byte_idx) && $stable(chunk_idx)));

  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ACC && dat_valid && dat_ready && chunk_idx != LAST)
      |=> (byte_idx == CHUNK_AW'($past(byte_idx) + 1'b1)));

  p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_idx == LAST && mode != MODE_CLR) |=> (chunk_idx == LAST && byte_idx == '0));

  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && !code_ready && mode == MODE_READ) |=> $stable(code_data));

  p_valid_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> (mode == MODE_READ));

  p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_chunk == LAST) |-> !code_valid);

  p_rewind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_READ) |=> (rd_slot == 2'd0 && rd_chunk == '0));

endmodule

bind ecc_hamming_acc ecc_hamming_acc_chk #(.NCHUNKS(NCHUNKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .dat_valid (dat_valid),
  .dat_ready (dat_ready),
  .code_valid(code_valid),
  .code_ready(code_ready),
  .code_data (code_data),
  .byte_idx  (pos_byte),
  .chunk_idx (pos_chunk),
  .rd_slot   (rd_slot),
  .rd_chunk  (rd_chunk)
);

// File: tb/ecc_hamming_acc_test.sv
`timescale 1ns/1ps
module ecc_hamming_acc_test;

  localparam int NCH   = 2;
  localparam int TOTAL = NCH * 256;
  localparam int NCODE = NCH * 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       dat_valid = 1'b0;
  logic       dat_ready = 1'b0;
  logic [7:0] dat_byte = 8'h00;
  logic       code_valid;
  logic       code_ready = 1'b0;
  logic [7:0] code_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] mem [TOTAL];
  int n_acc = 0;

  always #4 clk = ~clk;

  ecc_hamming_acc #(.NCHUNKS(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
    .code_valid(code_valid), .code_ready(code_ready), .code_data(code_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected code byte in stream order: byte1, byte0, byte2 per chunk
  function automatic logic [7:0] exp_code(input int idx);
    int c = idx / 3;
    int s = idx % 3;
    logic [15:0] lp = '0;
    logic [5:0]  cp = '0;
    for (int i = 0; i < 256; i++) begin
      int pos = c * 256 + i;
      if (pos < n_acc) begin
        logic [7:0] b = mem[pos];
        logic p = ^b;
        for (int k = 0; k < 8; k++)
          if (((i >> k) & 1) != 0) lp[2*k+1] ^= p; else lp[2*k] ^= p;
        cp[0] ^= b[0] ^ b[2] ^ b[4] ^ b[6];
        cp[1] ^= b[1] ^ b[3] ^ b[5] ^ b[7];
        cp[2] ^= b[0] ^ b[1] ^ b[4] ^ b[5];
        cp[3] ^= b[2] ^ b[3] ^ b[6] ^ b[7];
        cp[4] ^= b[0] ^ b[1] ^ b[2] ^ b[3];
        cp[5] ^= b[4] ^ b[5] ^ b[6] ^ b[7];
      end
    end
    if (s == 0) return ~lp[15:8];
    if (s == 1) return ~lp[7:0];
    return {~cp, 2'b11};
  endfunction

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    dat_valid = 1'b0;
    dat_ready = 1'b0;
    mode = m;
    if (m == 2'b11) n_acc = 0;
  endtask

  task automatic beat(input logic [7:0] d, input bit v, input bit r);
    @(negedge clk);
    dat_valid = v;
    dat_ready = r;
    dat_byte = d;
    if (v && r && mode == 2'b01 && n_acc < TOTAL) begin
      mem[n_acc] = d;
      n_acc++;
    end
  endtask

  task automatic start_acc();
    set_mode(2'b11);
    set_mode(2'b00);
    set_mode(2'b01);
  endtask

  // read whole code stream, stalling on two bytes (R8), then check end (R9)
  task automatic read_check(input string tag);
    set_mode(2'b00);
    set_mode(2'b10);
    for (int idx = 0; idx < NCODE; idx++) begin
      if (idx == 1 || idx == 4) begin
        code_ready = 1'b0;
        #1;
        chk(code_data == exp_code(idx), {tag, " R8 stall data"}, code_data, exp_code(idx));
        @(negedge clk);
      end
      code_ready = 1'b1;
      #1;
      chk(code_valid == 1'b1, {tag, " R8 valid"}, code_valid, 1);
      chk(code_data == exp_code(idx), {tag, " R5/R6/R8 code byte"}, code_data, exp_code(idx));
      @(negedge clk);
      code_ready = 1'b0;
    end
    #1;
    chk(code_valid == 1'b0, {tag, " R9 drained"}, code_valid, 0);
    code_ready = 1'b1;
    @(negedge clk);
    #1;
    chk(code_valid == 1'b0, {tag, " R9 stays low"}, code_valid, 0);
    code_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    int addrs [12] = '{0, 1, 2, 4, 8, 16, 32, 64, 128, 255, 170, 85};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(code_valid == 1'b0, "R1 reset valid", code_valid, 0);
    n_acc = 0;
    read_check("R1 reset");

    // full page with stalled, unaccepted beats mixed in (R3, R7)
    start_acc();
    lfsr = 16'hACE1;
    for (int i = 0; i < TOTAL; i++) begin
      if (i % 7 == 3) beat(8'h5A, 1'b1, 1'b0);
      if (i % 11 == 5) beat(8'hC3, 1'b0, 1'b1);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      beat(lfsr[7:0], 1'b1, 1'b1);
    end
    // beyond the page: ignored (R7)
    for (int i = 0; i < 20; i++) beat(8'hFF, 1'b1, 1'b1);
    read_check("R3 R7 page");
    read_check("R11 reread");

    // rewind after partial read (R10)
    set_mode(2'b10);
    code_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    code_ready = 1'b0;
    set_mode(2'b00);
    set_mode(2'b10);
    #1;
    chk(code_data == exp_code(0), "R10 rewind data", code_data, exp_code(0));
    chk(code_valid == 1'b1, "R10 rewind valid", code_valid, 1);

    // beats during read-out mode are ignored (R2)
    for (int i = 0; i < 10; i++) beat(8'(i * 37 + 1), 1'b1, 1'b1);
    read_check("R2 read-mode beats");

    // freeze in the middle of a chunk (R2)
    start_acc();
    for (int i = 0; i < 100; i++) beat(8'(i * 13 + 7), 1'b1, 1'b1);
    set_mode(2'b00);
    for (int i = 0; i < 50; i++) beat(8'hE7, 1'b1, 1'b1);
    set_mode(2'b01);
    for (int i = 0; i < 156; i++) beat(8'(i ^ 8'h96), 1'b1, 1'b1);
    read_check("R2 freeze");

    // clear empties code (R4)
    set_mode(2'b11);
    set_mode(2'b00);
    read_check("R4 clear");

    // clear colliding with a handshaken beat (R4)
    @(negedge clk);
    mode = 2'b11;
    n_acc = 0;
    dat_valid = 1'b1;
    dat_ready = 1'b1;
    dat_byte = 8'hA5;
    set_mode(2'b00);
    set_mode(2'b01);
    for (int i = 0; i < 256; i++) beat(8'(i * 3), 1'b1, 1'b1);
    read_check("R4 collision");

    // single-bit sweep in chunk 0 (R5, R6)
    foreach (addrs[j]) begin
      for (int k = 0; k < 8; k++) begin
        start_acc();
        for (int i = 0; i < 256; i++)
          beat((i == addrs[j]) ? 8'(1 << k) : 8'h00, 1'b1, 1'b1);
        read_check("R5 R6 single bit");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule